// File: doc/BRIEF.md
# Bayer Block-Binning Colour Downscaler

This block takes a raster stream of raw Bayer sensor samples, one sample per valid cycle, and reduces the image by collapsing whole square tiles of the mosaic into single RGB pixels. It is meant to sit between a sensor capture front end and a preview or video path that wants a quarter-area or sixteenth-area picture. There is no neighbourhood interpolation. Each output pixel is built only from the samples inside its own tile. Tiles never overlap, because the tile steps across the line and down the frame by its own size.

The input carries a start-of-frame flag on the first sample of a frame and an end-of-line flag on the last sample of each line. A 3-bit mode code selects 2x2 tiles, 4x4 tiles or full resolution. The code is captured only on the start-of-frame sample. In full resolution the block passes each raw sample through as a grey RGB triple; demosaicing is handled elsewhere.

For 4x4 tiles, partial per-tile sums are held across lines in a column-sum store. Each output pixel appears one cycle after the sample that completes its tile. The frame carries two extra trailing lines as a timing margin, and these lines give no binned output.

Top module: `bayer_bin_scaler`

## Requirements
- R1: The mode code maps as follows. 3'b100 selects full resolution. 3'b011 and 3'b010 select 2x2 tiles. 3'b001 and 3'b000 select 4x4 tiles. The unused codes 3'b101, 3'b110 and 3'b111 behave as full resolution.
- R2: In full resolution, every valid input sample produces one output one cycle later with out_r = out_g = out_b = the sample, and out_eol equal to the input end-of-line flag.
- R3: The mosaic phase is RGGB. A sample on an even line and even column is red. A sample on an odd line and odd column is blue. Every other sample is green. Lines and columns are counted from 0 at start of frame.
- R4: In 2x2 mode, one output is issued one cycle after the bottom-right sample of each tile. Its values are red, (green0 + green1) >> 1, and blue.
- R5: In 4x4 mode, one output is issued one cycle after the bottom-right sample of each tile. Its values are the sum of the 4 reds >> 2, the sum of the 8 greens >> 3, and the sum of the 4 blues >> 2.
- R6: Tiles step by their own size in both directions. A line of width W, which must be a multiple of the tile size, yields W/N outputs once every N lines and none on the other lines.
- R7: out_eol is high on exactly the output produced by the tile that contains the input end-of-line sample, and on no other output.
- R8: In either binning mode, lines with index ACT_LINES or greater (the margin lines) produce no output.
- R9: The mode code is sampled only on a valid start-of-frame sample. Changes at any other time have no effect until the next start of frame.
- R10: After reset, out_valid is low. A valid start-of-frame sample is position (0,0) even if it arrives in the middle of a frame, and it restarts tile formation.
- R11: Idle cycles (in_valid low) produce no output and do not advance the position. The column count returns to 0 after an end-of-line sample, and the line count then advances by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_sof | input | 1 | First sample of a frame (with in_valid) |
| in_eol | input | 1 | Last sample of a line (with in_valid) |
| in_pix | input | 8 | Raw Bayer sample |
| mode_code | input | 3 | Scaling mode, captured at start of frame |
| out_valid | output | 1 | Output pixel valid |
| out_eol | output | 1 | Last output pixel of an output line |
| out_r | output | 8 | Red value |
| out_g | output | 8 | Green value |
| out_b | output | 8 | Blue value |

## Verification
The assertions check several things on every cycle. An output only follows a valid input. The line marker never appears without a valid output. The column count wraps after end-of-line. Start of frame lands at the origin. The latched mode holds between starts of frame. Binned outputs never come from margin lines. The averaged colour values, the tile-by-tile output counts and the effect of mid-frame mode changes are shown only by the bench's frames, where each frame is compared cycle by cycle against a behavioural model that averages each tile directly from a stored image.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int PIX_W = 8;
    localparam int SUM_W = PIX_W + 3;

    typedef enum logic [1:0] {
        MD_FULL = 2'd0,
        MD_BIN2 = 2'd1,
        MD_BIN4 = 2'd2
    } bin_mode_e;

    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2
    } bayer_ch_e;

    typedef struct packed {
        logic [SUM_W-1:0] r;
        logic [SUM_W-1:0] g;
        logic [SUM_W-1:0] b;
    } rgb_sum_t;

    typedef struct packed {
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } rgb_pix_t;

    function automatic bin_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'b011, 3'b010: decode_mode = MD_BIN2;
            3'b001, 3'b000: decode_mode = MD_BIN4;
            default:        decode_mode = MD_FULL;
        endcase
    endfunction

    function automatic bayer_ch_e site_colour(input logic row_odd, input logic col_odd);
        if (!row_odd && !col_odd)     site_colour = CH_RED;
        else if (row_odd && col_odd)  site_colour = CH_BLUE;
        else                          site_colour = CH_GREEN;
    endfunction

    function automatic rgb_sum_t add_sum(input rgb_sum_t a, input rgb_sum_t b);
        add_sum.r = a.r + b.r;
        add_sum.g = a.g + b.g;
        add_sum.b = a.b + b.b;
    endfunction

endpackage

// File: rtl/bss_pos_tracker.sv
module bss_pos_tracker
    import bss_pkg::*;
#(
    parameter int MAX_W = 640,
    parameter int MAX_H = 512,
    localparam int X_W = $clog2(MAX_W),
    localparam int Y_W = $clog2(MAX_H)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic           in_sof,
    input  logic           in_eol,
    input  logic [2:0]     mode_code,
    output logic [X_W-1:0] cur_x,
    output logic [Y_W-1:0] cur_y,
    output bin_mode_e      cur_mode
);

    logic [X_W-1:0] x_q;
    logic [Y_W-1:0] y_q;
    bin_mode_e      mode_q;

    always_comb begin
        cur_x    = in_sof ? '0 : x_q;
        cur_y    = in_sof ? '0 : y_q;
        cur_mode = in_sof ? decode_mode(mode_code) : mode_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q    <= '0;
            y_q    <= '0;
            mode_q <= MD_FULL;
        end else if (in_valid) begin
            mode_q <= cur_mode;
            if (in_eol) begin
                x_q <= '0;
                y_q <= cur_y + Y_W'(1);
            end else begin
                x_q <= cur_x + X_W'(1);
                y_q <= cur_y;
            end
        end
    end

    a_r11_col_wraps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eol) |=> (x_q == '0));

    a_r10_sof_origin: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && !in_eol) |=> (x_q == X_W'(1) && y_q == '0));

    a_r9_mode_held: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_sof) |=> $stable(mode_q));

endmodule

// File: rtl/bss_col_accum.sv
module bss_col_accum
    import bss_pkg::*;
#(
    parameter int MAX_W     = 640,
    parameter int MAX_H     = 512,
    parameter int ACT_LINES = 480,
    localparam int X_W   = $clog2(MAX_W),
    localparam int Y_W   = $clog2(MAX_H),
    localparam int DEPTH = MAX_W / 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix,
    input  logic [X_W-1:0]   cur_x,
    input  logic [Y_W-1:0]   cur_y,
    input  bin_mode_e        cur_mode,
    output logic             emit,
    output rgb_pix_t         win_avg
);

    localparam logic [Y_W-1:0] ACT_Y = Y_W'(ACT_LINES);

    rgb_sum_t       col_mem [DEPTH];
    rgb_sum_t       acc_q;
    rgb_sum_t       contrib, acc_now, prior, total;
    logic           is4, binning, in_area, last_col, last_row, wr_en;
    logic [1:0]     lmask, lx, ly;
    logic [IDX_W-1:0] wx;
    bayer_ch_e      ch;

    always_comb begin
        is4      = (cur_mode == MD_BIN4);
        binning  = (cur_mode != MD_FULL);
        in_area  = (cur_y < ACT_Y);
        lmask    = is4 ? 2'b11 : 2'b01;
        lx       = cur_x[1:0] & lmask;
        ly       = cur_y[1:0] & lmask;
        last_col = (lx == lmask);
        last_row = (ly == lmask);
        wx       = IDX_W'(is4 ? (cur_x >> 2) : (cur_x >> 1));

        ch        = site_colour(cur_y[0], cur_x[0]);
        contrib   = '0;
        case (ch)
            CH_RED:   contrib.r = SUM_W'(pix);
            CH_BLUE:  contrib.b = SUM_W'(pix);
            default:  contrib.g = SUM_W'(pix);
        endcase

        acc_now = add_sum((lx == 2'b00) ? '0 : acc_q, contrib);
        prior   = (ly == 2'b00) ? '0 : col_mem[wx];
        total   = add_sum(prior, acc_now);

        emit  = pix_valid && binning && in_area && last_col && last_row;
        wr_en = pix_valid && binning && last_col && !last_row;

        if (is4) begin
            win_avg.r = total.r[PIX_W+1:2];
            win_avg.g = total.g[PIX_W+2:3];
            win_avg.b = total.b[PIX_W+1:2];
        end else begin
            win_avg.r = total.r[PIX_W-1:0];
            win_avg.g = total.g[PIX_W:1];
            win_avg.b = total.b[PIX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else if (pix_valid) acc_q <= acc_now;
    end

    always_ff @(posedge clk) begin
        if (wr_en) col_mem[wx] <= total;
    end

endmodule

// File: rtl/bss_out_stage.sv
module bss_out_stage
    import bss_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic             pix_eol,
    input  logic [PIX_W-1:0] pix,
    input  bin_mode_e        cur_mode,
    input  logic             emit,
    input  rgb_pix_t         win_avg,
    output logic             out_valid,
    output logic             out_eol,
    output rgb_pix_t         out_pix
);

    logic full, pass_now, fire;

    always_comb begin
        full     = (cur_mode == MD_FULL);
        pass_now = pix_valid && full;
        fire     = pass_now || emit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_eol   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= fire;
            out_eol   <= fire && pix_eol;
            if (pass_now)  out_pix <= '{r: pix, g: pix, b: pix};
            else if (emit) out_pix <= win_avg;
        end
    end

endmodule

// File: rtl/bayer_bin_scaler.sv
module bayer_bin_scaler
    import bss_pkg::*;
#(
    parameter int MAX_W     = 640,
    parameter int MAX_H     = 512,
    parameter int ACT_LINES = 480
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eol,
    input  logic [7:0] in_pix,
    input  logic [2:0] mode_code,
    output logic       out_valid,
    output logic       out_eol,
    output logic [7:0] out_r,
    output logic [7:0] out_g,
    output logic [7:0] out_b
);

    localparam int X_W = $clog2(MAX_W);
    localparam int Y_W = $clog2(MAX_H);
    localparam logic [Y_W-1:0] ACT_Y = Y_W'(ACT_LINES);

    logic [X_W-1:0] cur_x;
    logic [Y_W-1:0] cur_y;
    bin_mode_e      cur_mode;
    logic           emit;
    rgb_pix_t       win_avg, out_pix;

    bss_pos_tracker #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_track (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .mode_code(mode_code),
        .cur_x(cur_x), .cur_y(cur_y), .cur_mode(cur_mode)
    );

    bss_col_accum #(.MAX_W(MAX_W), .MAX_H(MAX_H), .ACT_LINES(ACT_LINES)) u_accum (
        .clk(clk), .rst(rst), .pix_valid(in_valid), .pix(in_pix),
        .cur_x(cur_x), .cur_y(cur_y), .cur_mode(cur_mode),
        .emit(emit), .win_avg(win_avg)
    );

    bss_out_stage u_out (
        .clk(clk), .rst(rst), .pix_valid(in_valid), .pix_eol(in_eol),
        .pix(in_pix), .cur_mode(cur_mode), .emit(emit), .win_avg(win_avg),
        .out_valid(out_valid), .out_eol(out_eol), .out_pix(out_pix)
    );

    assign out_r = out_pix.r;
    assign out_g = out_pix.g;
    assign out_b = out_pix.b;

    a_r2_out_follows_in: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    a_r7_eol_has_valid: assert property (@(posedge clk) disable iff (rst)
        out_eol |-> out_valid);

    a_r8_margin_quiet: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(cur_mode) != MD_FULL) |-> ($past(cur_y) < ACT_Y));

endmodule

// File: tb/bayer_bin_scaler_tb_top.sv
module bayer_bin_scaler_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 16;
    localparam int ACT = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_sof, in_eol;
    logic [7:0] in_pix;
    logic [2:0] mode_code;
    logic       out_valid, out_eol;
    logic [7:0] out_r, out_g, out_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    bayer_bin_scaler #(.MAX_W(W), .MAX_H(32), .ACT_LINES(ACT)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
        .in_eol(in_eol), .in_pix(in_pix), .mode_code(mode_code),
        .out_valid(out_valid), .out_eol(out_eol),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    typedef struct {
        bit v;
        bit eol;
        int r;
        int g;
        int b;
    } exp_t;

    exp_t  exp_q[$];
    int    vectors = 0;
    int    misses  = 0;
    string tag;
    bit    done = 0;

    int img [0:31][0:15];
    int m_n = 0;
    int m_x = 0;
    int m_y = 0;

    function automatic int tile_of(input logic [2:0] code);
        if (code == 3'b011 || code == 3'b010) return 2;
        if (code == 3'b001 || code == 3'b000) return 4;
        return 0;
    endfunction

    function automatic exp_t model(input bit v, input bit sof, input bit eol, input int p,
                                   input logic [2:0] code);
        exp_t e;
        e = '{v: 0, eol: 0, r: 0, g: 0, b: 0};
        if (!v) return e;
        if (sof) begin
            m_n = tile_of(code);
            m_x = 0;
            m_y = 0;
        end
        img[m_y][m_x] = p;
        if (m_n == 0) begin
            e = '{v: 1, eol: eol, r: p, g: p, b: p};
        end else if ((m_x % m_n) == m_n - 1 && (m_y % m_n) == m_n - 1 && m_y < ACT) begin
            int rs, gs, bs;
            rs = 0; gs = 0; bs = 0;
            for (int yy = m_y - m_n + 1; yy <= m_y; yy++)
                for (int xx = m_x - m_n + 1; xx <= m_x; xx++) begin
                    if (yy % 2 == 0 && xx % 2 == 0)      rs += img[yy][xx];
                    else if (yy % 2 == 1 && xx % 2 == 1) bs += img[yy][xx];
                    else                                 gs += img[yy][xx];
                end
            e = '{v: 1, eol: eol, r: rs / (m_n*m_n/4), g: gs / (m_n*m_n/2), b: bs / (m_n*m_n/4)};
        end
        if (eol) begin
            m_x = 0;
            m_y++;
        end else begin
            m_x++;
        end
        return e;
    endfunction

    task automatic compare();
        exp_t e;
        e = exp_q.pop_front();
        vectors++;
        if (out_valid !== e.v) begin
            misses++;
            $display("FAIL %s valid: actual %0b expected %0b", tag, out_valid, e.v);
        end else if (e.v) begin
            if (out_r != e.r[7:0] || out_g != e.g[7:0] || out_b != e.b[7:0]) begin
                misses++;
                $display("FAIL %s rgb: actual %0d/%0d/%0d expected %0d/%0d/%0d",
                         tag, out_r, out_g, out_b, e.r, e.g, e.b);
            end
            if (out_eol !== e.eol) begin
                misses++;
                $display("FAIL R7 eol: actual %0b expected %0b", out_eol, e.eol);
            end
        end
    endtask

    task automatic step(input bit v, input bit sof, input bit eol, input int p,
                        input logic [2:0] code);
        in_valid  = v;
        in_sof    = sof;
        in_eol    = eol;
        in_pix    = p[7:0];
        mode_code = code;
        exp_q.push_back(model(v, sof, eol, p, code));
        @(negedge clk);
        compare();
    endtask

    task automatic run_frame(input logic [2:0] code, input logic [2:0] later_code,
                             input int lines, input int seed, input bit gaps);
        for (int y = 0; y < lines; y++)
            for (int x = 0; x < W; x++) begin
                if (gaps && ((x + 3*y + seed) % 5 == 0))
                    step(0, 0, 0, 0, later_code);
                step(1, (x == 0 && y == 0), (x == W - 1),
                     (x*37 + y*91 + seed*13 + x*y*7) & 255,
                     (x == 0 && y == 0) ? code : later_code);
            end
        step(0, 0, 0, 0, later_code);
        step(0, 0, 0, 0, later_code);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        in_valid = 0; in_sof = 0; in_eol = 0; in_pix = 0; mode_code = 3'b100;
        repeat (3) @(negedge clk);
        tag = "R10";
        vectors++;
        if (out_valid !== 1'b0) begin
            misses++;
            $display("FAIL R10 reset: actual %0b expected 0", out_valid);
        end
        rst = 1'b0;
        @(negedge clk);

        tag = "R2";        run_frame(3'b100, 3'b100, 3, 1, 0);
        tag = "R3,R4";     run_frame(3'b011, 3'b011, 4, 2, 0);
        tag = "R6";        run_frame(3'b010, 3'b010, 6, 3, 0);
        tag = "R5";        run_frame(3'b001, 3'b001, 8, 4, 0);
        tag = "R8";        run_frame(3'b000, 3'b000, ACT + 2, 5, 0);
        tag = "R1";        run_frame(3'b101, 3'b101, 2, 6, 0);
        tag = "R1 code111"; run_frame(3'b111, 3'b111, 2, 7, 0);
        tag = "R9";        run_frame(3'b001, 3'b100, 8, 8, 0);
        tag = "R9 to2x2";  run_frame(3'b100, 3'b011, 2, 9, 0);
        tag = "R11";       run_frame(3'b011, 3'b000, ACT + 2, 10, 1);
        tag = "R10 abort"; run_frame(3'b001, 3'b001, 3, 11, 0);
        tag = "R10";       run_frame(3'b001, 3'b001, 8, 12, 1);
        tag = "R7";        run_frame(3'b010, 3'b010, 4, 13, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule